// File: doc/BRIEF.md
# Interlaced Vertical Timing Generator

This block counts display lines and turns the count into vertical video timing: an active-video flag, a blanking flag, a vertical sync pulse, a field indicator and the current line number. A horizontal timing block gives it one strobe per line. Two vertical timing sets are held. The primary set drives progressive frames and odd fields. A separate even set supplies the total and active counts for even fields when interlacing is on.

Software programs the block through a write-only port into staging registers. Staged values have no effect until software sets an update bit. The values are then copied into the working registers at the next frame or field boundary, and the update bit clears itself.

The block also takes a panel height. When the panel is taller than the active area, it computes a centering offset and moves the blank and sync windows up by that amount. An adjusted position that would go below zero is held at zero.

Top module: `vtg_top`

## Requirements
- R1: After reset the line count is 0, the field indicator is 0 (odd), the update-pending flag is 0, and the outputs are blanked: blank high, active low, vsync low. They stay blanked until the first load of the working registers.
- R2: Write map, addressed by `wr_addr_i`:
  - 0 is control: bit0 requests an update, bit1 enables interlace.
  - 1 is the primary set: total in bits 26:16, active in bits 10:0.
  - 2 is the even set, with the same layout.
  - 3 is blanking: end in 26:16, start in 10:0.
  - 4 is sync: end in 26:16, start in 10:0.
  - 5 is the panel height minus one, in bits 10:0.
  - Totals and actives are line counts minus one.
- R3: Staged values do not change any output until the working registers are loaded. A load happens only at a line-counter wrap while an update is pending.
- R4: `upd_pend_o` goes high on a control write with bit0 set. It clears in the same edge that loads the working registers.
- R5: On each line strobe the line count increments. After reaching the selected total, the next strobe returns it to 0; that strobe is the boundary.
- R6: With interlace enabled, the field indicator toggles at every wrap. Field 1 (even) uses the even total and active. Field 0 uses the primary set.
- R7: With interlace disabled, the field indicator is 0 after every wrap and only the primary set is used.
- R8: `active_o` is high while loaded and the line count is at or below the selected active count.
- R9: Once loaded, `blank_o` is high for lines in [adjusted blank start, adjusted blank end). `vsync_o` is high for lines in [adjusted sync start, adjusted sync end).
- R10: `vadj_o` equals (panel − selected active) / 2, rounded down, when the panel is larger; otherwise it is 0. The four blank and sync positions are each reduced by it.
- R11: An adjusted position saturates at 0 when the offset exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_stb_i | input | 1 | One-cycle pulse per display line |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 32 | Register write data |
| active_o | output | 1 | Active video line |
| blank_o | output | 1 | Vertical blanking |
| vsync_o | output | 1 | Vertical sync |
| field_o | output | 1 | 0 = odd/progressive, 1 = even field |
| line_o | output | 11 | Current line count |
| vadj_o | output | 11 | Vertical centering offset |
| upd_pend_o | output | 1 | Update request pending |

## Verification
A wrong working register shows up as a shifted active, blank or sync window within one line strobe after the bad load. A wrong line count or field bit changes the wrap point. That misplaces the next frame boundary and flips which total applies. A stale or early load is visible in two ways: the first line after a boundary, and `upd_pend_o` still high or already low at that boundary. Each strobe is compared against a reference model built from the requirements, so one bad line is caught on the strobe that produced it.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned LW     = 11;
  localparam int unsigned HI_LSB = 16;
  localparam int unsigned AW     = 3;
  localparam int unsigned DW     = 32;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 3'd0,
    A_PRIM  = 3'd1,
    A_EVEN  = 3'd2,
    A_BLANK = 3'd3,
    A_SYNC  = 3'd4,
    A_PANEL = 3'd5
  } vaddr_t;

  typedef struct packed {
    logic [LW-1:0] p_tot;
    logic [LW-1:0] p_act;
    logic [LW-1:0] e_tot;
    logic [LW-1:0] e_act;
    logic [LW-1:0] b_start;
    logic [LW-1:0] b_end;
    logic [LW-1:0] s_start;
    logic [LW-1:0] s_end;
    logic [LW-1:0] panel;
    logic          ilace;
  } vset_t;

  function automatic logic [LW-1:0] sat_sub(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wrap_i,
  output vset_t         work_o,
  output logic          loaded_o,
  output logic          pend_o,
  output logic          ilace_next_o
);
  vset_t stage_q, work_q;
  logic  pend_q, loaded_q, load, set_req;
  logic  unused_bits;

  assign unused_bits = ^{wr_data_i[DW-1:HI_LSB+LW], wr_data_i[HI_LSB-1:LW]};
  assign set_req = wr_en_i && (vaddr_t'(wr_addr_i) == A_CTRL) && wr_data_i[0];
  assign load    = wrap_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (wr_en_i) begin
      case (vaddr_t'(wr_addr_i))
        A_CTRL:  stage_q.ilace <= wr_data_i[1];
        A_PRIM:  begin
          stage_q.p_tot <= wr_data_i[HI_LSB +: LW];
          stage_q.p_act <= wr_data_i[0 +: LW];
        end
        A_EVEN:  begin
          stage_q.e_tot <= wr_data_i[HI_LSB +: LW];
          stage_q.e_act <= wr_data_i[0 +: LW];
        end
        A_BLANK: begin
          stage_q.b_end   <= wr_data_i[HI_LSB +: LW];
          stage_q.b_start <= wr_data_i[0 +: LW];
        end
        A_SYNC:  begin
          stage_q.s_end   <= wr_data_i[HI_LSB +: LW];
          stage_q.s_start <= wr_data_i[0 +: LW];
        end
        A_PANEL: stage_q.panel <= wr_data_i[0 +: LW];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q   <= '0;
      loaded_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= (pend_q && !load) || set_req;
      if (load) begin
        work_q   <= stage_q;
        loaded_q <= 1'b1;
      end
    end
  end

  assign work_o       = work_q;
  assign loaded_o     = loaded_q;
  assign pend_o       = pend_q;
  assign ilace_next_o = load ? stage_q.ilace : work_q.ilace;

  // R4
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && pend_q && !set_req) |=> !pend_o);
  // R3
  work_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wrap_i && pend_q) |=> $stable(work_o));
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
  import vtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_stb_i,
  input  logic [LW-1:0] tot_i,
  input  logic          ilace_next_i,
  output logic [LW-1:0] line_o,
  output logic          field_o,
  output logic          wrap_o
);
  logic [LW-1:0] line_q;
  logic          field_q;

  assign wrap_o = line_stb_i && (line_q == tot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      field_q <= 1'b0;
    end else if (wrap_o) begin
      line_q  <= '0;
      field_q <= ilace_next_i ? !field_q : 1'b0;
    end else if (line_stb_i) begin
      line_q  <= line_q + LW'(1);
    end
  end

  assign line_o  = line_q;
  assign field_o = field_q;

  // R5
  line_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o <= tot_i);
  // R7
  prog_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !ilace_next_i) |=> !field_o);
  // R6
  ilace_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && ilace_next_i) |=> (field_o != $past(field_o)));
endmodule

// File: rtl/vtg_center.sv
module vtg_center
  import vtg_pkg::*;
(
  input  vset_t         work_i,
  input  logic          field_i,
  input  logic          loaded_i,
  input  logic [LW-1:0] line_i,
  output logic          active_o,
  output logic          blank_o,
  output logic          vsync_o,
  output logic [LW-1:0] vadj_o
);
  logic [LW-1:0] act_sel, adj, abs_q, abe, ass, ase;

  assign act_sel = field_i ? work_i.e_act : work_i.p_act;
  assign adj     = (work_i.panel > act_sel) ? ((work_i.panel - act_sel) >> 1) : '0;

  assign abs_q = sat_sub(work_i.b_start, adj);
  assign abe   = sat_sub(work_i.b_end,   adj);
  assign ass   = sat_sub(work_i.s_start, adj);
  assign ase   = sat_sub(work_i.s_end,   adj);

  assign active_o = loaded_i && (line_i <= act_sel);
  assign blank_o  = !loaded_i || ((line_i >= abs_q) && (line_i < abe));
  assign vsync_o  = loaded_i && (line_i >= ass) && (line_i < ase);
  assign vadj_o   = adj;
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_stb_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [31:0]   wr_data_i,
  output logic          active_o,
  output logic          blank_o,
  output logic          vsync_o,
  output logic          field_o,
  output logic [10:0]   line_o,
  output logic [10:0]   vadj_o,
  output logic          upd_pend_o
);
  vset_t         work;
  logic          loaded, ilace_next, wrap;
  logic [LW-1:0] tot_sel;

  assign tot_sel = field_o ? work.e_tot : work.p_tot;

  vtg_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .wrap_i(wrap), .work_o(work), .loaded_o(loaded),
    .pend_o(upd_pend_o), .ilace_next_o(ilace_next)
  );

  vtg_counter u_cnt (
    .clk_i, .rst_ni, .line_stb_i, .tot_i(tot_sel),
    .ilace_next_i(ilace_next), .line_o, .field_o, .wrap_o(wrap)
  );

  vtg_center u_ctr (
    .work_i(work), .field_i(field_o), .loaded_i(loaded), .line_i(line_o),
    .active_o, .blank_o, .vsync_o, .vadj_o
  );

  // R1
  idle_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded |-> (blank_o && !active_o && !vsync_o));
  // R10
  vadj_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vadj_o <= work.panel);
endmodule

// File: tb/vtg_top_test.sv
module vtg_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        active, blank, vsync, field, pend;
  logic [10:0] line, vadj;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vtg_top uut (
    .clk_i(clk), .rst_ni(rst_n), .line_stb_i(stb), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .active_o(active),
    .blank_o(blank), .vsync_o(vsync), .field_o(field), .line_o(line),
    .vadj_o(vadj), .upd_pend_o(pend)
  );

  typedef struct {
    logic [10:0] line;
    logic        field, act, blk, vs, pend;
    logic [10:0] vadj;
  } exp_t;

  exp_t q[$];
  event go;

  // Reference model state: staging (s_*) and working (w_*)
  logic [10:0] s_pt, s_pa, s_et, s_ea, s_bs, s_be, s_ss, s_se, s_pn;
  logic        s_il;
  logic [10:0] w_pt, w_pa, w_et, w_ea, w_bs, w_be, w_ss, w_se, w_pn;
  logic        w_il;
  logic        m_loaded, m_pend, m_field;
  logic [10:0] m_line;

  function automatic logic [10:0] ssub(logic [10:0] a, logic [10:0] b);
    return (a > b) ? a - b : 11'd0;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic exp_t model_out();
    exp_t e;
    logic [10:0] a, adj;
    a   = m_field ? w_ea : w_pa;
    adj = (w_pn > a) ? (w_pn - a) >> 1 : 11'd0;
    e.line  = m_line;
    e.field = m_field;
    e.pend  = m_pend;
    e.vadj  = adj;
    e.act   = m_loaded && (m_line <= a);
    e.blk   = !m_loaded || (m_line >= ssub(w_bs, adj) && m_line < ssub(w_be, adj));
    e.vs    = m_loaded && (m_line >= ssub(w_ss, adj) && m_line < ssub(w_se, adj));
    return e;
  endfunction

  task automatic model_step();
    logic [10:0] t;
    t = m_field ? w_et : w_pt;
    if (m_line == t) begin
      if (m_pend) begin
        {w_pt, w_pa, w_et, w_ea, w_bs, w_be, w_ss, w_se, w_pn, w_il} =
          {s_pt, s_pa, s_et, s_ea, s_bs, s_be, s_ss, s_se, s_pn, s_il};
        m_loaded = 1'b1;
        m_pend   = 1'b0;
      end
      m_field = w_il ? !m_field : 1'b0;
      m_line  = '0;
    end else begin
      m_line = m_line + 11'd1;
    end
  endtask

  // R2: register layout {5'b0, hi[10:0], 5'b0, lo[10:0]}
  task automatic wr(logic [2:0] a, logic [10:0] hi, logic [10:0] lo);
    @(posedge clk);
    wr_en   <= 1'b1;
    wr_addr <= a;
    wr_data <= {5'b0, hi, 5'b0, lo};
    @(posedge clk);
    wr_en   <= 1'b0;
    case (a)
      3'd0: begin s_il = lo[1]; if (lo[0]) m_pend = 1'b1; end
      3'd1: begin s_pt = hi; s_pa = lo; end
      3'd2: begin s_et = hi; s_ea = lo; end
      3'd3: begin s_be = hi; s_bs = lo; end
      3'd4: begin s_se = hi; s_ss = lo; end
      3'd5: s_pn = lo;
      default: ;
    endcase
  endtask

  // Driver: one line strobe, expected outputs pushed to the scoreboard
  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      stb <= 1'b1;
      @(posedge clk);
      stb <= 1'b0;
      model_step();
      q.push_back(model_out());
      -> go;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  // Monitor
  initial begin
    forever begin
      exp_t e;
      @(go);
      @(negedge clk);
      e = q.pop_front();
      chk("R5", "line", int'(line), int'(e.line));
      chk("R6/R7", "field", int'(field), int'(e.field));
      chk("R8", "active", int'(active), int'(e.act));
      chk("R9", "blank", int'(blank), int'(e.blk));
      chk("R9", "vsync", int'(vsync), int'(e.vs));
      chk("R10/R11", "vadj", int'(vadj), int'(e.vadj));
      chk("R4", "pend", int'(pend), int'(e.pend));
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    {s_pt, s_pa, s_et, s_ea, s_bs, s_be, s_ss, s_se, s_pn, s_il} = '0;
    {w_pt, w_pa, w_et, w_ea, w_bs, w_be, w_ss, w_se, w_pn, w_il} = '0;
    m_loaded = 0; m_pend = 0; m_field = 0; m_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "line", int'(line), 0);
    chk("R1", "field", int'(field), 0);
    chk("R1", "blank", int'(blank), 1);
    chk("R1", "active", int'(active), 0);
    chk("R1", "vsync", int'(vsync), 0);
    chk("R1", "pend", int'(pend), 0);

    // R2/R3: staged writes without update leave outputs blanked
    wr(3'd1, 11'd9, 11'd5);
    wr(3'd3, 11'd9, 11'd6);
    wr(3'd4, 11'd8, 11'd7);
    wr(3'd5, 11'd0, 11'd5);
    strobe(3);
    @(negedge clk);
    chk("R3", "blank before update", int'(blank), 1);

    // R4: update request pends, loads at next boundary, then self-clears (R7 progressive)
    wr(3'd0, 11'd0, 11'd1);
    @(negedge clk);
    chk("R4", "pend after request", int'(pend), 1);
    strobe(25);
    @(negedge clk);
    chk("R4", "pend after load", int'(pend), 0);

    // R3: new values staged mid-frame must wait for boundary + update
    wr(3'd1, 11'd6, 11'd4);
    strobe(12);
    wr(3'd0, 11'd0, 11'd1);
    strobe(16);

    // R6: interlace, even set differs from primary
    wr(3'd2, 11'd7, 11'd3);
    wr(3'd1, 11'd9, 11'd5);
    wr(3'd0, 11'd0, 11'd3);
    strobe(40);

    // R10/R11: centering with offset 3 (odd) and 4 (even); sync start saturates
    wr(3'd5, 11'd0, 11'd11);
    wr(3'd4, 11'd4, 11'd2);
    wr(3'd3, 11'd9, 11'd6);
    wr(3'd0, 11'd0, 11'd3);
    strobe(40);

    // R7: back to progressive, field returns to 0
    wr(3'd0, 11'd0, 11'd1);
    strobe(25);
    @(negedge clk);
    chk("R7", "field progressive", int'(field), 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule